// File: doc/BRIEF.md
# Vector Memory Alignment Unit

This block sits between a vector register file and a byte-addressed memory built from lines that are one vector wide (128 bytes by default). It accepts one vector load or store request at a time and turns it into one or two whole-line accesses on a synchronous memory port. Aligned accesses drop the in-line offset and touch exactly the containing line. Unaligned accesses use the exact byte address. They read or write the two neighbouring lines in ascending order and rotate the bytes so that vector byte 0 lands on the addressed byte.

Stores never read memory first. Each line write carries per-byte enables, so bytes outside the written span and lanes that a predicate masks off keep their old contents. A predicate holds one bit per 32-bit word lane. The four bytes of a lane share that bit. An inverted form writes the lanes whose bit is clear.

Requests and responses use valid/ready. A request is taken only while the unit is idle. Its fields must stay stable while `req_valid` is high and `req_ready` is low. A response stays on the port, unchanged, until the consumer raises `rsp_ready`, and no new request is taken before then. The memory port has no back-pressure. Read data is expected one cycle after a read is issued.

Top module: `vma_align_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0. Once a request is accepted, `req_ready` stays 0 until its response has been taken.
- R2: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_rdata` does not change.
- R3: A load with `req_unaligned`=0 ignores address bits [OFF_W-1:0], issues exactly one read of line `req_addr>>OFF_W`, and returns that line, with byte b on bits [8b+7:8b].
- R4: A store with `req_unaligned`=0 and `req_pred`=0 ignores the low address bits and `req_lane_pred`, and writes all bytes of the containing line in one access.
- R5: A load with `req_unaligned`=1 and nonzero offset k returns, in byte b, the memory byte at address `req_addr`+b, gathered from lines L and L+1.
- R6: A store with `req_unaligned`=1 and offset k writes byte i of line L (i>=k) with vector byte i-k, and byte i of line L+1 (i<k) with vector byte LINE_BYTES-k+i. All other bytes of both lines keep their old values.
- R7: An unaligned request whose offset is zero issues exactly one line access and behaves like the aligned request.
- R8: A store with `req_pred`=1 writes the bytes 4j..4j+3 of lane j only when `req_lane_pred[j]` XOR `req_pred_inv` is 1. Masked-off bytes keep their old values.
- R9: A two-line access issues line L and then line L+1 in consecutive cycles.
- R10: A load never asserts `mem_we` or any `mem_be` bit, so memory is unchanged. A store's response carries all-zero `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken on this edge |
| req_store | input | 1 | 1 = store, 0 = load |
| req_unaligned | input | 1 | 1 = use exact byte address |
| req_pred | input | 1 | 1 = store is predicated by lanes |
| req_pred_inv | input | 1 | 1 = write lanes whose predicate bit is clear |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | LINE_BYTES*8 | Store vector, byte b on bits [8b+7:8b] |
| req_lane_pred | input | LINE_BYTES/4 | One predicate bit per word lane |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | LINE_BYTES*8 | Loaded vector, zero for stores |
| mem_en | output | 1 | Line access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_line | output | ADDR_W-OFF_W | Line index |
| mem_wdata | output | LINE_BYTES*8 | Write data for the line |
| mem_be | output | LINE_BYTES | Per-byte write enables |
| mem_rdata | input | LINE_BYTES*8 | Read data, one cycle after a read |

## Verification
The assertions assume the memory answers every read in the next cycle. They also assume request fields hold steady while a request waits, because the offset and the write data are captured on the accepting edge. The bench memory model always has one cycle of read latency. The bench changes request fields only on the falling edge before a request is raised, and keeps them until the request is taken. The bench keeps two-line accesses inside its modelled lines, so line L+1 always exists.

// File: rtl/vma_pkg.sv
package vma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ISSUE0 = 3'd1,
    ST_ISSUE1 = 3'd2,
    ST_TAIL   = 3'd3,
    ST_RESP   = 3'd4
  } vma_state_e;

endpackage

// File: rtl/vma_lane_mask.sv
module vma_lane_mask #(
  parameter int LINE_BYTES = 128
) (
  input  logic [LINE_BYTES/4-1:0] lane_pred,
  input  logic                    use_pred,
  input  logic                    invert,
  output logic [LINE_BYTES-1:0]   byte_en
);
  localparam int LANES = LINE_BYTES / 4;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic sel;
    assign sel = use_pred ? (lane_pred[j] ^ invert) : 1'b1;
    assign byte_en[4*j +: 4] = {4{sel}};
  end

endmodule

// File: rtl/vma_load_merge.sv
module vma_load_merge #(
  parameter int LINE_BYTES = 128
) (
  input  logic [LINE_BYTES*8-1:0]       lo_line,
  input  logic [LINE_BYTES*8-1:0]       hi_line,
  input  logic [$clog2(LINE_BYTES)-1:0] offset,
  output logic [LINE_BYTES*8-1:0]       vec
);
  localparam int VW    = LINE_BYTES * 8;
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W+2:0] shamt;
  assign shamt = {offset, 3'b000};

  // Byte b of the result is byte (offset+b) of the concatenated pair.
  assign vec = VW'({hi_line, lo_line} >> shamt);

endmodule

// File: rtl/vma_store_shape.sv
module vma_store_shape #(
  parameter int LINE_BYTES = 128
) (
  input  logic [LINE_BYTES*8-1:0]       wdata,
  input  logic [LINE_BYTES-1:0]         byte_en,
  input  logic [$clog2(LINE_BYTES)-1:0] offset,
  output logic [LINE_BYTES*8-1:0]       first_data,
  output logic [LINE_BYTES-1:0]         first_be,
  output logic [LINE_BYTES*8-1:0]       second_data,
  output logic [LINE_BYTES-1:0]         second_be
);
  localparam int VW    = LINE_BYTES * 8;
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W+2:0]          dshift;
  logic [2*VW-1:0]           wide_d;
  logic [2*LINE_BYTES-1:0]   wide_e;

  assign dshift = {offset, 3'b000};
  assign wide_d = {{VW{1'b0}}, wdata} << dshift;
  assign wide_e = {{LINE_BYTES{1'b0}}, byte_en} << offset;

  assign first_data  = wide_d[VW-1:0];
  assign second_data = wide_d[2*VW-1:VW];
  assign first_be    = wide_e[LINE_BYTES-1:0];
  assign second_be   = wide_e[2*LINE_BYTES-1:LINE_BYTES];

endmodule

// File: rtl/vma_align_unit.sv
module vma_align_unit
  import vma_pkg::*;
#(
  parameter int LINE_BYTES = 128,
  parameter int ADDR_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_store,
  input  logic                              req_unaligned,
  input  logic                              req_pred,
  input  logic                              req_pred_inv,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [LINE_BYTES*8-1:0]           req_wdata,
  input  logic [LINE_BYTES/4-1:0]           req_lane_pred,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [LINE_BYTES*8-1:0]           rsp_rdata,
  output logic                              mem_en,
  output logic                              mem_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_line,
  output logic [LINE_BYTES*8-1:0]           mem_wdata,
  output logic [LINE_BYTES-1:0]             mem_be,
  input  logic [LINE_BYTES*8-1:0]           mem_rdata
);
  localparam int VW     = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  vma_state_e         st_q;
  logic               store_q;
  logic               two_q;
  logic [OFF_W-1:0]   off_q;
  logic [LINE_W-1:0]  line_q;
  logic [VW-1:0]      wdata_q;
  logic [LINE_BYTES-1:0] ben_q;
  logic [VW-1:0]      lo_q;
  logic [VW-1:0]      hi_q;

  logic [LINE_BYTES-1:0] req_ben;
  logic [OFF_W-1:0]      req_off;
  logic                  accept;

  logic [VW-1:0]         first_data, second_data, merged;
  logic [LINE_BYTES-1:0] first_be, second_be;

  vma_lane_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
    .lane_pred (req_lane_pred),
    .use_pred  (req_pred),
    .invert    (req_pred_inv),
    .byte_en   (req_ben)
  );

  vma_store_shape #(.LINE_BYTES(LINE_BYTES)) u_shape (
    .wdata       (wdata_q),
    .byte_en     (ben_q),
    .offset      (off_q),
    .first_data  (first_data),
    .first_be    (first_be),
    .second_data (second_data),
    .second_be   (second_be)
  );

  vma_load_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .lo_line (lo_q),
    .hi_line (hi_q),
    .offset  (off_q),
    .vec     (merged)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_off   = req_unaligned ? req_addr[OFF_W-1:0] : '0;

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      store_q <= 1'b0;
      two_q   <= 1'b0;
      off_q   <= '0;
      line_q  <= '0;
      wdata_q <= '0;
      ben_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            store_q <= req_store;
            off_q   <= req_off;
            two_q   <= (req_off != '0);
            line_q  <= req_addr[ADDR_W-1:OFF_W];
            wdata_q <= req_wdata;
            ben_q   <= req_ben;
            st_q    <= ST_ISSUE0;
          end
        end
        ST_ISSUE0: begin
          if (two_q)        st_q <= ST_ISSUE1;
          else if (store_q) st_q <= ST_RESP;
          else              st_q <= ST_TAIL;
        end
        ST_ISSUE1: begin
          if (!store_q) lo_q <= mem_rdata;
          st_q <= store_q ? ST_RESP : ST_TAIL;
        end
        ST_TAIL: begin
          if (two_q) hi_q <= mem_rdata;
          else       lo_q <= mem_rdata;
          st_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Memory port drive
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_line  = line_q;
    mem_wdata = first_data;
    mem_be    = '0;
    if (st_q == ST_ISSUE0) begin
      mem_en = 1'b1;
      mem_we = store_q;
      mem_be = store_q ? first_be : '0;
    end else if (st_q == ST_ISSUE1) begin
      mem_en    = 1'b1;
      mem_we    = store_q;
      mem_line  = line_q + 1'b1;
      mem_wdata = second_data;
      mem_be    = store_q ? second_be : '0;
    end
  end

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = store_q ? '0 : merged;

  // Checks
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready) else $error("ready after accept"); // R1

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)) else $error("response dropped"); // R2

  AST_LINE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) |-> mem_line == $past(mem_line) + 1'b1) else $error("line order"); // R9

  AST_ZERO_OFF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && $past(mem_en) |-> off_q != '0) else $error("second access at zero offset"); // R7

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !store_q |-> !mem_we && mem_be == '0) else $error("load wrote"); // R10

  AST_SPLIT_BE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_ISSUE1 && store_q |->
      $countones(mem_be) + $countones($past(mem_be)) == $countones(ben_q)) else $error("split enables"); // R6

  AST_SINGLE_BE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_ISSUE0 && store_q && !two_q |-> $countones(mem_be) == $countones(ben_q))
    else $error("single enables"); // R8

endmodule

// File: tb/vma_align_unit_test.sv
module vma_align_unit_test;
  localparam int LB = 16;
  localparam int AW = 12;
  localparam int VW = LB * 8;
  localparam int LN = LB / 4;
  localparam int OW = $clog2(LB);
  localparam int LW = AW - OW;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid, req_ready, req_store, req_unaligned, req_pred, req_pred_inv;
  logic [AW-1:0] req_addr;
  logic [VW-1:0] req_wdata;
  logic [LN-1:0] req_lane_pred;
  logic          rsp_valid, rsp_ready;
  logic [VW-1:0] rsp_rdata;
  logic          mem_en, mem_we;
  logic [LW-1:0] mem_line;
  logic [VW-1:0] mem_wdata;
  logic [LB-1:0] mem_be;
  logic [VW-1:0] mem_rdata;

  vma_align_unit #(.LINE_BYTES(LB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_unaligned(req_unaligned), .req_pred(req_pred), .req_pred_inv(req_pred_inv),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lane_pred(req_lane_pred),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_line(mem_line),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem_m [NL][LB];
  logic [7:0] mem_x [NL][LB];

  // Synchronous line memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      for (int b = 0; b < LB; b++) begin
        mem_rdata[8*b +: 8] <= mem_m[mem_line[2:0]][b];
        if (mem_we && mem_be[b]) mem_m[mem_line[2:0]][b] <= mem_wdata[8*b +: 8];
      end
    end
  end

  int acc_total = 0;
  logic [LW-1:0] acc_log [1024];
  always begin
    @(negedge clk);
    #1;
    if (rst_n && mem_en) begin
      acc_log[acc_total % 1024] = mem_line;
      acc_total = acc_total + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] line_of(input int l);
    logic [VW-1:0] v;
    for (int b = 0; b < LB; b++) v[8*b +: 8] = mem_x[l][b];
    return v;
  endfunction

  function automatic logic [VW-1:0] span_at(input int a);
    logic [VW-1:0] v;
    for (int b = 0; b < LB; b++) v[8*b +: 8] = mem_x[(a+b)/LB][(a+b)%LB];
    return v;
  endfunction

  task automatic cmp_mem(input string req);
    logic [VW-1:0] m, x;
    for (int l = 0; l < NL; l++) begin
      for (int b = 0; b < LB; b++) begin
        m[8*b +: 8] = mem_m[l][b];
        x[8*b +: 8] = mem_x[l][b];
      end
      chk(m === x, req, "memory line", m, x);
    end
  endtask

  task automatic run(input bit st, input bit un, input bit pr, input bit iv,
                     input int a, input logic [VW-1:0] wd, input logic [LN-1:0] pm,
                     input int stall, output logic [VW-1:0] rd, output int nacc,
                     output logic [LW-1:0] l0, output logic [LW-1:0] l1);
    int start;
    bit ok;
    @(negedge clk);
    start = acc_total;
    req_store = st; req_unaligned = un; req_pred = pr; req_pred_inv = iv;
    req_addr = AW'(a); req_wdata = wd; req_lane_pred = pm;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready while busy", VW'(req_ready), '0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    ok = 1'b1;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_rdata !== rd) ok = 1'b0;
    end
    if (stall > 0) chk(ok, "R2", "held response", rsp_rdata, rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    nacc = acc_total - start;
    l0 = acc_log[start % 1024];
    l1 = acc_log[(start + 1) % 1024];
  endtask

  initial begin
    logic [VW-1:0] rd, wd;
    int nacc;
    logic [LW-1:0] l0, l1;
    req_valid = 0; req_store = 0; req_unaligned = 0; req_pred = 0; req_pred_inv = 0;
    req_addr = '0; req_wdata = '0; req_lane_pred = '0; rsp_ready = 0;
    for (int l = 0; l < NL; l++)
      for (int b = 0; b < LB; b++) begin
        mem_m[l][b] = 8'(((l*LB + b) * 7 + 3) % 256);
        mem_x[l][b] = 8'(((l*LB + b) * 7 + 3) % 256);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "reset ready", VW'(req_ready), VW'(1));
    chk(rsp_valid === 1'b0, "R1", "reset rsp_valid", VW'(rsp_valid), '0);
    chk(mem_en === 1'b0, "R1", "reset mem_en", VW'(mem_en), '0);

    // Aligned loads, every line, every ignored offset
    for (int l = 0; l < NL; l++)
      for (int o = 0; o < LB; o++) begin
        run(0, 0, 0, 0, l*LB + o, '0, '0, o % 3, rd, nacc, l0, l1);
        chk(rd === line_of(l), "R3", "aligned load data", rd, line_of(l));
        chk(nacc == 1, "R3", "aligned load accesses", VW'(nacc), VW'(1));
        chk(l0 == LW'(l), "R3", "aligned load line", VW'(l0), VW'(l));
      end

    // Unaligned loads, every offset
    for (int l = 0; l < NL-1; l++)
      for (int o = 0; o < LB; o++) begin
        run(0, 1, 0, 0, l*LB + o, '0, '0, (l + o) % 2, rd, nacc, l0, l1);
        chk(rd === span_at(l*LB + o), o != 0 ? "R5" : "R7", "unaligned load data",
            rd, span_at(l*LB + o));
        chk(nacc == (o != 0 ? 2 : 1), o != 0 ? "R5" : "R7", "unaligned load accesses",
            VW'(nacc), VW'(o != 0 ? 2 : 1));
        if (o != 0) chk(l0 == LW'(l) && l1 == LW'(l + 1), "R9", "line order",
                        VW'({l0, l1}), VW'({LW'(l), LW'(l + 1)}));
      end
    cmp_mem("R10");

    // Unaligned stores, every offset
    for (int o = 0; o < LB; o++) begin
      int l;
      l = 1 + (o % 5);
      for (int b = 0; b < LB; b++) begin
        wd[8*b +: 8] = 8'((o*29 + b*13 + 5) % 256);
        mem_x[(l*LB + o + b)/LB][(l*LB + o + b)%LB] = wd[8*b +: 8];
      end
      run(1, 1, 0, 0, l*LB + o, wd, '0, o % 2, rd, nacc, l0, l1);
      chk(rd === '0, "R10", "store response data", rd, '0);
      chk(nacc == (o != 0 ? 2 : 1), o != 0 ? "R6" : "R7", "unaligned store accesses",
          VW'(nacc), VW'(o != 0 ? 2 : 1));
      if (o != 0) chk(l0 == LW'(l) && l1 == LW'(l + 1), "R9", "store line order",
                      VW'({l0, l1}), VW'({LW'(l), LW'(l + 1)}));
      cmp_mem("R6");
    end

    // Aligned store with low bits set and predicate bits ignored
    for (int b = 0; b < LB; b++) begin
      wd[8*b +: 8] = 8'((b*5 + 200) % 256);
      mem_x[6][b] = wd[8*b +: 8];
    end
    run(1, 0, 0, 0, 6*LB + 9, wd, '0, 1, rd, nacc, l0, l1);
    chk(nacc == 1, "R4", "aligned store accesses", VW'(nacc), VW'(1));
    cmp_mem("R4");

    // Predicated stores, all lane patterns, both polarities
    for (int iv = 0; iv < 2; iv++)
      for (int p = 0; p < (1 << LN); p++) begin
        for (int b = 0; b < LB; b++) begin
          wd[8*b +: 8] = 8'((p*17 + iv*91 + b*7) % 256);
          if ((((p >> (b/4)) & 1) ^ iv) == 1) mem_x[7][b] = wd[8*b +: 8];
        end
        run(1, 0, 1, iv[0], 7*LB + p, wd, LN'(p), 0, rd, nacc, l0, l1);
        chk(nacc == 1 && l0 == LW'(7), "R8", "predicated store access",
            VW'({nacc[7:0], l0}), VW'({8'd1, LW'(7)}));
        cmp_mem("R8");
      end

    // Read back through the ports
    run(0, 0, 0, 0, 7*LB, '0, '0, 2, rd, nacc, l0, l1);
    chk(rd === line_of(7), "R3", "read back", rd, line_of(7));

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule